// File: doc/BRIEF.md
# Buck Regulator Startup and Hiccup Retry Sequencer

This block is the digital sequencer of a voltage-mode synchronous buck controller. It takes the converter from power-up to regulation and handles shorted-output faults. It watches a power-good flag from the supply monitor, a shutdown comparator flag, a completion flag from the trip-level sampler and a trip flag from the low-side current comparator. It drives a soft-start reference code, a switching enable, a request for the trip-level sampler, and a hold-low command for both gate drivers.

Every duration is counted in ticks of a free-running prescaler, so the sequence timing does not depend on the switching frequency. After a start the block waits a fixed delay and then requests one trip-level sample. It then ramps the reference code from zero to full scale in equal steps and enters regulation. A trip while switching stops the power stage at once. The block then waits two dummy ramp-length intervals with the gates held low and retries the ramp. It never samples the trip level again during retries. A shutdown or a loss of power-good resets the sequence, so the next start runs the whole initialization again, including sampling.

Top module: `buck_startup_seq`

## Requirements
- R1: After reset, and for as long as `por_ok_i` is 0 or `disable_i` is 1, the block is idle: `ref_code_o`=0, `switch_en_o`=0, `sample_req_o`=0, `ramp_done_o`=0 and `gates_low_o`=1.
- R2: `disable_i`=1 in any state makes the block idle on the next clock. After release the block reruns the full initialization, delay and trip-level sampling included.
- R3: The clock edge after both start conditions hold begins the delay. `sample_req_o` rises at the edge of the DELAY_TICKS-th prescaler tick after that. A tick occurs every PRESCALE clocks and runs free from reset.
- R4: `sample_req_o` stays 1 until `sample_done_i`=1 is seen. At that edge the ramp starts with `switch_en_o`=1 and `ref_code_o`=0. `sample_done_i` has no effect in any other state.
- R5: During the ramp, `ref_code_o` holds each value for STEP_TICKS ticks and then rises by exactly one, from 0 to 2^CODE_W-1.
- R6: Once the top code has been held for its full step, `ramp_done_o` becomes 1. `ref_code_o` then stays at 2^CODE_W-1 while regulation lasts.
- R7: `oc_trip_i`=1 while `switch_en_o`=1 gives `switch_en_o`=0, `gates_low_o`=1, `ref_code_o`=0 and `ramp_done_o`=0 on the next clock.
- R8: After a trip the block waits two dummy intervals of STEP_TICKS*2^CODE_W ticks each, then starts a new ramp from code 0 without raising `sample_req_o`. This repeats for every later trip.
- R9: `oc_trip_i` has no effect while switching is off (idle, delay, sampling, dummy intervals).
- R10: `por_ok_i`=0 forces the idle outputs on the next clock from any state and takes priority over every other input. Power returning reruns the full initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Bias supply above its power-on threshold |
| disable_i | input | 1 | Shutdown request (compensation node held low) |
| sample_done_i | input | 1 | Trip-level sample and hold has finished |
| oc_trip_i | input | 1 | Low-side current comparator tripped |
| ref_code_o | output | CODE_W | Soft-start reference code |
| switch_en_o | output | 1 | Power stage switching allowed |
| sample_req_o | output | 1 | Run the trip-level sample and hold |
| gates_low_o | output | 1 | Hold both gate drivers low |
| ramp_done_o | output | 1 | Ramp finished, regulating |

## Verification
The bench builds the block with PRESCALE=3, STEP_TICKS=2, DELAY_TICKS=5 and the full 6-bit code. A complete ramp then fits in 384 clocks and a hiccup wait fits in 768 clocks. Several trips, shutdowns and power losses can therefore be placed in delay, sampling, ramp, regulation and dummy phases within one short run. A prescale above one also makes the tick phase offset from state entry visible, so the measured state durations test both ends of their one-tick uncertainty.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
package bss_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_DELAY   = 3'd1,
      ST_SAMPLE  = 3'd2,
      ST_SOFT    = 3'd3,
      ST_RUN     = 3'd4,
      ST_DUMMY1  = 3'd5,
      ST_DUMMY2  = 3'd6
   } seq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/bss_tick.sv
`timescale 1ns/1ps
module bss_tick #(
   parameter int PRESCALE = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (PRESCALE == 1) begin : g_every_clock
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b1;
            else        tick_q <= 1'b1;
         end
         assign tick_o = tick_q;
      end else begin : g_divider
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
         logic [PW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              div_q <= '0;
            else if (div_q == LAST)  div_q <= '0;
            else                     div_q <= div_q + PW'(1);
         end
         assign tick_o = (div_q == LAST);

         AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o); // R3
      end
   endgenerate
endmodule

// File: rtl/bss_interval.sv
`timescale 1ns/1ps
module bss_interval #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          count_en_i,
   input  logic          tick_i,
   input  logic [TW-1:0] limit_i,
   output logic          expire_o
);
   logic [TW-1:0] cnt_q;

   assign expire_o = count_en_i && tick_i && (cnt_q == (limit_i - TW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clear_i)                cnt_q <= '0;
      else if (count_en_i && tick_i)   cnt_q <= cnt_q + TW'(1);
   end

   AST_INTERVAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_en_i |-> (cnt_q < limit_i)); // R3
endmodule

// File: rtl/bss_ramp.sv
`timescale 1ns/1ps
module bss_ramp #(
   parameter int CODE_W     = 6,
   parameter int STEP_TICKS = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              advance_i,
   input  logic              tick_i,
   output logic [CODE_W-1:0] code_o,
   output logic              at_top_o,
   output logic              step_end_o
);
   localparam int SW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
   localparam logic [SW-1:0] STEP_LAST = SW'(STEP_TICKS - 1);

   logic [SW-1:0]     step_q;
   logic [CODE_W-1:0] code_q;

   assign at_top_o   = (code_q == '1);
   assign step_end_o = advance_i && tick_i && (step_q == STEP_LAST);
   assign code_o     = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         code_q <= '0;
      end else if (clear_i) begin
         step_q <= '0;
         code_q <= '0;
      end else if (advance_i && tick_i) begin
         if (step_q == STEP_LAST) begin
            step_q <= '0;
            if (!at_top_o) code_q <= code_q + CODE_W'(1);
         end else begin
            step_q <= step_q + SW'(1);
         end
      end
   end

   AST_CODE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (at_top_o && !clear_i) |=> (code_o == '1)); // R6
endmodule

// File: rtl/buck_startup_seq.sv
`timescale 1ns/1ps
module buck_startup_seq
   import bss_pkg::*;
#(
   parameter int PRESCALE    = 1000,
   parameter int DELAY_TICKS = 680,
   parameter int STEP_TICKS  = 11,
   parameter int CODE_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_ok_i,
   input  logic              disable_i,
   input  logic              sample_done_i,
   input  logic              oc_trip_i,
   output logic [CODE_W-1:0] ref_code_o,
   output logic              switch_en_o,
   output logic              sample_req_o,
   output logic              gates_low_o,
   output logic              ramp_done_o
);
   localparam int RAMP_TICKS = STEP_TICKS * (1 << CODE_W);
   localparam int MAX_TICKS  = max2(DELAY_TICKS, RAMP_TICKS);
   localparam int TW         = $clog2(MAX_TICKS + 1);

   generate
      if (PRESCALE < 1)    begin : g_bad_prescale $error("PRESCALE must be at least 1");    end
      if (DELAY_TICKS < 1) begin : g_bad_delay    $error("DELAY_TICKS must be at least 1"); end
      if (STEP_TICKS < 1)  begin : g_bad_step     $error("STEP_TICKS must be at least 1");  end
      if (CODE_W < 2 || CODE_W > 10) begin : g_bad_width $error("CODE_W out of range 2..10"); end
   endgenerate

   seq_state_t    state_q, state_d;
   logic          tick;
   logic          expire;
   logic          step_end;
   logic          at_top;
   logic          go;
   logic          timing_state;
   logic [TW-1:0] limit;

   bss_tick #(.PRESCALE(PRESCALE)) i_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   assign timing_state = (state_q == ST_DELAY) || (state_q == ST_DUMMY1) ||
                         (state_q == ST_DUMMY2);
   assign limit = (state_q == ST_DELAY) ? TW'(DELAY_TICKS) : TW'(RAMP_TICKS);

   bss_interval #(.TW(TW)) i_interval (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (state_d != state_q),
      .count_en_i (timing_state),
      .tick_i     (tick),
      .limit_i    (limit),
      .expire_o   (expire)
   );

   bss_ramp #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS)) i_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    ((state_d != ST_SOFT) && (state_d != ST_RUN)),
      .advance_i  (state_q == ST_SOFT),
      .tick_i     (tick),
      .code_o     (ref_code_o),
      .at_top_o   (at_top),
      .step_end_o (step_end)
   );

   assign go = por_ok_i && !disable_i;

   always_comb begin
      state_d = state_q;
      if (!go) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:   state_d = ST_DELAY;
            ST_DELAY:  if (expire) state_d = ST_SAMPLE;
            ST_SAMPLE: if (sample_done_i) state_d = ST_SOFT;
            ST_SOFT: begin
               if (oc_trip_i)              state_d = ST_DUMMY1;
               else if (step_end && at_top) state_d = ST_RUN;
            end
            ST_RUN:    if (oc_trip_i) state_d = ST_DUMMY1;
            ST_DUMMY1: if (expire) state_d = ST_DUMMY2;
            ST_DUMMY2: if (expire) state_d = ST_SOFT;
            default:   state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign switch_en_o  = (state_q == ST_SOFT) || (state_q == ST_RUN);
   assign gates_low_o  = !switch_en_o;
   assign sample_req_o = (state_q == ST_SAMPLE);
   assign ramp_done_o  = (state_q == ST_RUN);

   AST_IDLE_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!por_ok_i || disable_i) |=> (!switch_en_o && !sample_req_o && ref_code_o == '0)); // R1
   AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      disable_i |=> (gates_low_o && !ramp_done_o)); // R2
   AST_POR_LOSS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !por_ok_i |=> (state_q == ST_IDLE)); // R10
   AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_en_o && oc_trip_i) |=> (!switch_en_o && ref_code_o == '0)); // R7
   AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (switch_en_o && !oc_trip_i && go) |=>
         (ref_code_o == $past(ref_code_o) || ref_code_o == $past(ref_code_o) + CODE_W'(1))); // R5
   AST_DONE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_done_o |-> (ref_code_o == '1)); // R6
   AST_SAMPLE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sample_req_o) |-> ($past(state_q) == ST_DELAY)); // R8
   AST_RETRY_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DUMMY2) |=> !sample_req_o); // R8
   AST_TRIP_IGNORED_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DUMMY1 && go && !expire) |=> (state_q == ST_DUMMY1)); // R9
endmodule

// File: tb/test_buck_startup_seq.sv
`timescale 1ns/1ps
module test_buck_startup_seq;
   localparam int P   = 3;
   localparam int S   = 2;
   localparam int D   = 5;
   localparam int CW  = 6;
   localparam int TOP = (1 << CW) - 1;
   localparam int RT  = S * (1 << CW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por = 1'b0, dis = 1'b0, sdone = 1'b0, trip = 1'b0;
   logic [CW-1:0] code;
   logic sw, sreq, glow, done;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   buck_startup_seq #(.PRESCALE(P), .DELAY_TICKS(D), .STEP_TICKS(S), .CODE_W(CW))
   i_buck_startup_seq (
      .clk(clk), .rst_n(rst_n), .por_ok_i(por), .disable_i(dis),
      .sample_done_i(sdone), .oc_trip_i(trip), .ref_code_o(code),
      .switch_en_o(sw), .sample_req_o(sreq), .gates_low_o(glow), .ramp_done_o(done)
   );

   // behavioural reference: phase 0 idle,1 delay,2 sample,3 ramp,4 regulate,5/6 dummy
   int pc = 0, ph = 0, rem = 0, srem = 0, mcode = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         pc = 0; ph = 0; rem = 0; srem = 0; mcode = 0;
      end else begin
         bit tk;
         tk = (pc == P - 1);
         pc = tk ? 0 : pc + 1;
         if (!por || dis) begin
            ph = 0; mcode = 0;
         end else begin
            case (ph)
               0: begin ph = 1; rem = D; end
               1: if (tk) begin rem--; if (rem == 0) ph = 2; end
               2: if (sdone) begin ph = 3; mcode = 0; srem = S; end
               3: if (trip) begin ph = 5; rem = RT; mcode = 0; end
                  else if (tk) begin
                     srem--;
                     if (srem == 0) begin
                        srem = S;
                        if (mcode == TOP) ph = 4; else mcode++;
                     end
                  end
               4: if (trip) begin ph = 5; rem = RT; mcode = 0; end
               5: if (tk) begin rem--; if (rem == 0) begin ph = 6; rem = RT; end end
               6: if (tk) begin rem--; if (rem == 0) begin ph = 3; srem = S; mcode = 0; end end
               default: ph = 0;
            endcase
         end
      end
   end

   function automatic string ph_tag(input int p);
      case (p)
         0: return "R1";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp_v);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int ev;
         ev = ((ph == 3 || ph == 4) ? 1 : 0) | ((ph == 2) ? 2 : 0) |
              ((ph == 4) ? 4 : 0) | ((ph == 3 || ph == 4) ? 0 : 8);
         chk({glow, done, sreq, sw} == 4'(ev), ph_tag(ph), int'({glow, done, sreq, sw}), ev, "flags vs model");
         chk(int'(code) == mcode, ph_tag(ph), int'(code), mcode, "code vs model");
      end
   end

   task automatic idle_chk(input string tag);
      chk(code == 0 && !sw && !sreq && glow && !done, tag,
          int'({code, sw, sreq, glow, done}), 2, "idle outputs");
   endtask

   // which: 0 sample request, 1 ramp done, 2 switching
   task automatic wait_for(input int which, output int n, output bit saw_req);
      n = 0; saw_req = 0;
      forever begin
         @(negedge clk);
         n++;
         if (sreq) saw_req = 1;
         if ((which == 0 && sreq) || (which == 1 && done) || (which == 2 && sw) || n > 5000) break;
      end
   endtask

   task automatic range_chk(input int n, input int lo, input int hi, input string tag, input string what);
      chk(n >= lo && n <= hi, tag, n, hi, what);
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1; @(negedge clk); sig = 1'b0;
   endtask

   initial begin
      int n; bit sr;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_chk("R1");
      // stray inputs while unpowered
      trip = 1; sdone = 1; @(negedge clk); trip = 0; sdone = 0;
      repeat (3) @(negedge clk);
      idle_chk("R9");
      idle_chk("R4");

      // power up: delay then sample request
      por = 1;
      wait_for(0, n, sr);
      range_chk(n, (D - 1) * P + 2, D * P + 1, "R3", "delay length");
      repeat (3) @(negedge clk);
      trip = 1; @(negedge clk); trip = 0;
      repeat (2) @(negedge clk);
      chk(sreq && !sw, "R4", int'({sreq, sw}), 2, "sample request held");
      chk(!sw && glow, "R9", int'({sw, glow}), 1, "trip ignored during sampling");

      sdone = 1; @(negedge clk); sdone = 0;
      chk(sw && !sreq && code == 0 && !glow, "R4", int'({sw, sreq, glow}), 4, "ramp starts at zero");
      wait_for(1, n, sr);
      range_chk(n, (64 * S - 1) * P + 1, 64 * S * P, "R5", "ramp length");
      chk(int'(code) == TOP, "R6", int'(code), TOP, "top code at done");
      sdone = 1; @(negedge clk); sdone = 0;
      repeat (8) @(negedge clk);
      chk(done && int'(code) == TOP, "R6", int'(code), TOP, "regulation holds top");

      // first hiccup from regulation
      trip = 1; @(negedge clk); trip = 0;
      chk(!sw && glow && code == 0 && !done, "R7", int'({sw, glow, done}), 2, "trip cuts switching");
      wait_for(2, n, sr);
      range_chk(n, (2 * RT - 1) * P + 1, 2 * RT * P, "R8", "two dummy intervals");
      chk(!sr, "R8", int'(sr), 0, "no sample during retry");

      // second hiccup from mid-ramp
      repeat (40) @(negedge clk);
      chk(code > 0 && int'(code) < TOP, "R5", int'(code), 6, "mid-ramp code");
      trip = 1; @(negedge clk); trip = 0;
      chk(!sw && code == 0, "R7", int'({sw, code}), 0, "trip mid ramp");
      repeat (20) @(negedge clk);
      trip = 1; @(negedge clk); trip = 0;
      wait_for(2, n, sr);
      range_chk(n, (2 * RT - 1) * P + 1 - 21, 2 * RT * P - 21, "R9", "trip ignored in dummy");
      chk(!sr, "R8", int'(sr), 0, "repeat retry without sampling");

      // shutdown in a dummy interval
      trip = 1; @(negedge clk); trip = 0;
      repeat (15) @(negedge clk);
      dis = 1; @(negedge clk);
      idle_chk("R2");
      repeat (5) @(negedge clk);
      idle_chk("R2");
      dis = 0;
      wait_for(0, n, sr);
      range_chk(n, (D - 1) * P + 2, D * P + 1, "R2", "full init after release");

      // power loss from regulation
      sdone = 1; @(negedge clk); sdone = 0;
      wait_for(1, n, sr);
      chk(done == 1'b1, "R6", int'(done), 1, "done reached again");
      por = 0; dis = 1; trip = 1; @(negedge clk); dis = 0; trip = 0;
      idle_chk("R10");
      repeat (4) @(negedge clk);
      por = 1;
      wait_for(0, n, sr);
      range_chk(n, (D - 1) * P + 2, D * P + 1, "R10", "init after power return");

      repeat (5) @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule